// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out store for 9-bit words. The write port and the read port run on independent clocks. The storage depth is a power-of-two parameter. The write domain reports full and almost-full, and the read domain reports empty and almost-empty. All four flags are active low. The words are kept in a dual-port array. Each pointer carries one extra wrap bit. A pointer crosses to the other domain as Gray code through a two-flop synchroniser. The read side loads a word into an output register, and a tri-state enable puts that register on the data bus.

The configuration pin is sampled while reset is held. High selects dual-enable mode: a write needs the first enable low and the configuration pin high, and both almost-flags use the fixed offset of 7. Low selects programmable mode: the first write enable alone starts a write, and the almost-flag thresholds come from two offset inputs that a separate offset-register block drives. A read always needs both active-low read enables.

Top module: `prog_flag_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, that domain's pointer returns to location 0. After the reset: `full_n`=1, `afull_n`=1, `empty_n`=0, `aempty_n`=0, and the output register holds 0.
- R2: The level of `wr_en2_ld` at a reset edge selects the mode: 1 is dual-enable and 0 is programmable. In programmable mode a write is accepted with `wr_en1_n`=0 whatever the level of `wr_en2_ld`.
- R3: In dual-enable mode a word is written only when `wr_en1_n`=0 and `wr_en2_ld`=1. With either enable inactive the stored count does not change.
- R4: The output register takes the next word only at a read-clock edge where `rd_en1_n`=0 and `rd_en2_n`=0. With either enable high, both the register and the stored count hold.
- R5: A write while full and a read while empty are ignored. Neither pointer moves, the stored words are not corrupted, and the output register holds.
- R6: Words come out in the order they were written, with their values unchanged, across pointer wrap-around.
- R7: `full_n` is 0 exactly when the count seen in the write domain equals DEPTH. It falls in the same write edge that accepts the DEPTH-th word.
- R8: `afull_n` is 0 when the write-domain count is at least DEPTH−m. In programmable mode m is `full_ofs`, and in dual-enable mode m is 7.
- R9: `empty_n` is 0 when the read-domain count is zero. `aempty_n` is 0 when that count is n or less, where n is `empty_ofs` in programmable mode and 7 in dual-enable mode.
- R10: When `out_en_n`=1, `rd_q` is high-impedance on all 9 bits. When `out_en_n`=0, `rd_q` shows the output register.
- R11: In dual-enable mode the offset inputs have no effect on either almost-flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Mode select at reset; second write enable (active high) in dual-enable mode |
| wr_data | input | 9 | Word to store |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| out_en_n | input | 1 | Output drive enable, active low |
| empty_ofs | input | log2(DEPTH) | Almost-empty offset n (programmable mode) |
| full_ofs | input | log2(DEPTH) | Almost-full offset m (programmable mode) |
| rd_q | output | 9 | Output register, tri-stated when disabled |
| full_n | output | 1 | Full flag, active low, write domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |
| empty_n | output | 1 | Empty flag, active low, read domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
The write pointer is a register, and full and almost-full are decoded from it combinationally. So `full_n` is due just after the write edge that accepts a word, and the bench samples it at the next falling write clock during each burst. A write reaches empty and almost-empty only after its Gray pointer passes two read-clock flops, and a read reaches the write flags two write-clock edges later. For this reason, every almost-flag and empty check follows a settle of four edges in each domain. A popped word is sampled at the falling read clock that follows the single enabled read edge.

// File: rtl/pff_pkg.sv
package pff_pkg;

    localparam int WORD_W      = 9;
    localparam int DEFAULT_OFS = 7;
    localparam int CONV_W      = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        MODE_DUAL_WEN = 1'b0,
        MODE_PROG     = 1'b1
    } cfg_mode_e;

    function automatic logic [CONV_W-1:0] bin2gray(input logic [CONV_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CONV_W-1:0] gray2bin(input logic [CONV_W-1:0] g);
        logic [CONV_W-1:0] b;
        b[CONV_W-1] = g[CONV_W-1];
        for (int i = CONV_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic cfg_mode_e decode_mode(input logic cfg_pin);
        return cfg_pin ? MODE_DUAL_WEN : MODE_PROG;
    endfunction

endpackage

// File: rtl/pff_sync.sv
module pff_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pff_mem.sv
module pff_mem #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                 wclk,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    waddr,
    input  pff_pkg::word_t       wdata,
    input  logic [ADDR_W-1:0]    raddr,
    output pff_pkg::word_t       rdata
);
    pff_pkg::word_t cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/pff_wr_side.sv
module pff_wr_side #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int PTR_W  = ADDR_W + 1
) (
    input  logic              wclk,
    input  logic              rst,
    input  logic              wen1_n,
    input  logic              wen2_cfg,
    input  logic [ADDR_W-1:0] full_ofs,
    input  logic [PTR_W-1:0]  rgray_sync,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [PTR_W-1:0]  wbin,
    output logic [PTR_W-1:0]  wgray,
    output logic              full_n,
    output logic              afull_n
);
    import pff_pkg::*;

    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    cfg_mode_e         mode_q;
    logic              enable_ok;
    logic [PTR_W-1:0]  rbin_sync;
    logic [PTR_W-1:0]  count;
    logic [PTR_W-1:0]  wbin_nxt;
    logic [ADDR_W-1:0] ofs_m;
    logic [PTR_W-1:0]  af_thresh;

    assign enable_ok = !wen1_n && ((mode_q == MODE_PROG) || wen2_cfg);
    assign we        = enable_ok && full_n;
    assign waddr     = wbin[ADDR_W-1:0];
    assign wbin_nxt  = wbin + PTR_W'(1);

    always_ff @(posedge wclk) begin
        if (rst) begin
            mode_q <= decode_mode(wen2_cfg);
            wbin   <= '0;
            wgray  <= '0;
        end else if (we) begin
            wbin   <= wbin_nxt;
            wgray  <= PTR_W'(bin2gray(CONV_W'(wbin_nxt)));
        end
    end

    assign rbin_sync = PTR_W'(gray2bin(CONV_W'(rgray_sync)));
    assign count     = wbin - rbin_sync;
    assign ofs_m     = (mode_q == MODE_PROG) ? full_ofs : ADDR_W'(DEFAULT_OFS);
    assign af_thresh = DEPTH_P - {1'b0, ofs_m};
    assign full_n    = (count != DEPTH_P);
    assign afull_n   = (count < af_thresh);
endmodule

// File: rtl/pff_rd_side.sv
module pff_rd_side #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int PTR_W  = ADDR_W + 1
) (
    input  logic              rclk,
    input  logic              rst,
    input  logic              cfg_pin,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic [ADDR_W-1:0] empty_ofs,
    input  logic [PTR_W-1:0]  wgray_sync,
    input  pff_pkg::word_t    mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  rbin,
    output logic [PTR_W-1:0]  rgray,
    output pff_pkg::word_t    q_reg,
    output logic              empty_n,
    output logic              aempty_n
);
    import pff_pkg::*;

    cfg_mode_e         mode_q;
    logic              pop;
    logic [PTR_W-1:0]  wbin_sync;
    logic [PTR_W-1:0]  count;
    logic [PTR_W-1:0]  rbin_nxt;
    logic [ADDR_W-1:0] ofs_n;

    assign pop      = !ren1_n && !ren2_n && empty_n;
    assign raddr    = rbin[ADDR_W-1:0];
    assign rbin_nxt = rbin + PTR_W'(1);

    always_ff @(posedge rclk) begin
        if (rst) begin
            mode_q <= decode_mode(cfg_pin);
            rbin   <= '0;
            rgray  <= '0;
            q_reg  <= '0;
        end else if (pop) begin
            rbin   <= rbin_nxt;
            rgray  <= PTR_W'(bin2gray(CONV_W'(rbin_nxt)));
            q_reg  <= mem_rdata;
        end
    end

    assign wbin_sync = PTR_W'(gray2bin(CONV_W'(wgray_sync)));
    assign count     = wbin_sync - rbin;
    assign ofs_n     = (mode_q == MODE_PROG) ? empty_ofs : ADDR_W'(DEFAULT_OFS);
    assign empty_n   = (count != '0);
    assign aempty_n  = (count > {1'b0, ofs_n});
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                        wclk,
    input  logic                        rclk,
    input  logic                        rst,
    input  logic                        wr_en1_n,
    input  logic                        wr_en2_ld,
    input  logic [pff_pkg::WORD_W-1:0]  wr_data,
    input  logic                        rd_en1_n,
    input  logic                        rd_en2_n,
    input  logic                        out_en_n,
    input  logic [ADDR_W-1:0]           empty_ofs,
    input  logic [ADDR_W-1:0]           full_ofs,
    output logic [pff_pkg::WORD_W-1:0]  rd_q,
    output logic                        full_n,
    output logic                        afull_n,
    output logic                        empty_n,
    output logic                        aempty_n
);
    import pff_pkg::*;

    localparam int PTR_W = ADDR_W + 1;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    word_t             mem_rdata;
    word_t             q_reg;
    logic [PTR_W-1:0]  wr_ptr_bin;
    logic [PTR_W-1:0]  rd_ptr_bin;
    logic [PTR_W-1:0]  wgray;
    logic [PTR_W-1:0]  rgray;
    logic [PTR_W-1:0]  wgray_at_r;
    logic [PTR_W-1:0]  rgray_at_w;

    pff_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    pff_wr_side #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_wr (
        .wclk       (wclk),
        .rst        (rst),
        .wen1_n     (wr_en1_n),
        .wen2_cfg   (wr_en2_ld),
        .full_ofs   (full_ofs),
        .rgray_sync (rgray_at_w),
        .we         (mem_we),
        .waddr      (mem_waddr),
        .wbin       (wr_ptr_bin),
        .wgray      (wgray),
        .full_n     (full_n),
        .afull_n    (afull_n)
    );

    pff_rd_side #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_rd (
        .rclk       (rclk),
        .rst        (rst),
        .cfg_pin    (wr_en2_ld),
        .ren1_n     (rd_en1_n),
        .ren2_n     (rd_en2_n),
        .empty_ofs  (empty_ofs),
        .wgray_sync (wgray_at_r),
        .mem_rdata  (mem_rdata),
        .raddr      (mem_raddr),
        .rbin       (rd_ptr_bin),
        .rgray      (rgray),
        .q_reg      (q_reg),
        .empty_n    (empty_n),
        .aempty_n   (aempty_n)
    );

    pff_sync #(.W(PTR_W)) u_sync_w2r (
        .clk (rclk),
        .rst (rst),
        .d   (wgray),
        .q   (wgray_at_r)
    );

    pff_sync #(.W(PTR_W)) u_sync_r2w (
        .clk (wclk),
        .rst (rst),
        .d   (rgray),
        .q   (rgray_at_w)
    );

    assign rd_q = out_en_n ? {WORD_W{1'bz}} : q_reg;
endmodule

// File: rtl/pff_chk.sv
module pff_chk #(
    parameter int PTR_W = 10
) (
    input logic                       wclk,
    input logic                       rclk,
    input logic                       rst,
    input logic                       full_n,
    input logic                       afull_n,
    input logic                       empty_n,
    input logic                       aempty_n,
    input logic                       rd_en1_n,
    input logic                       rd_en2_n,
    input logic [PTR_W-1:0]           wr_ptr,
    input logic [PTR_W-1:0]           rd_ptr,
    input logic [pff_pkg::WORD_W-1:0] q_reg
);
    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (rst)
        !full_n |=> (wr_ptr == $past(wr_ptr)));                        // R5
    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (rst)
        !empty_n |=> (rd_ptr == $past(rd_ptr)));                       // R5
    AST_READ_HOLD: assert property (@(posedge rclk) disable iff (rst)
        (rd_en1_n || rd_en2_n) |=> $stable(q_reg));                    // R4
    AST_READ_HOLD_PTR: assert property (@(posedge rclk) disable iff (rst)
        (rd_en1_n || rd_en2_n) |=> $stable(rd_ptr));                   // R4
    AST_WPTR_STEP: assert property (@(posedge wclk) disable iff (rst)
        PTR_W'(wr_ptr - $past(wr_ptr)) <= PTR_W'(1));                   // R6
    AST_FULL_HAS_AFULL: assert property (@(posedge wclk) disable iff (rst)
        !full_n |-> !afull_n);                                         // R8
    AST_EMPTY_HAS_AEMPTY: assert property (@(posedge rclk) disable iff (rst)
        !empty_n |-> !aempty_n);                                       // R9
endmodule

bind prog_flag_fifo pff_chk #(.PTR_W(PTR_W)) u_chk (
    .wclk     (wclk),
    .rclk     (rclk),
    .rst      (rst),
    .full_n   (full_n),
    .afull_n  (afull_n),
    .empty_n  (empty_n),
    .aempty_n (aempty_n),
    .rd_en1_n (rd_en1_n),
    .rd_en2_n (rd_en2_n),
    .wr_ptr   (wr_ptr_bin),
    .rd_ptr   (rd_ptr_bin),
    .q_reg    (q_reg)
);

// File: tb/prog_flag_fifo_tb.sv
module prog_flag_fifo_tb;
    localparam int DEPTH       = 16;
    localparam int ADDR_W      = $clog2(DEPTH);
    localparam int WCLK_PERIOD = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int WATCHDOG    = 1_000_000;

    logic              wclk = 1'b0;
    logic              rclk = 1'b0;
    logic              rst  = 1'b1;
    logic              wr_en1_n = 1'b1;
    logic              wr_en2_ld = 1'b0;
    logic [8:0]        wr_data = '0;
    logic              rd_en1_n = 1'b1;
    logic              rd_en2_n = 1'b1;
    logic              out_en_n = 1'b0;
    logic [ADDR_W-1:0] empty_ofs = '0;
    logic [ADDR_W-1:0] full_ofs  = '0;
    wire  [8:0]        rd_q;
    logic              full_n, afull_n, empty_n, aempty_n;

    int         checks = 0;
    int         errors = 0;
    int         seq    = 0;
    logic       dual   = 1'b0;
    logic [8:0] model [$];
    logic [8:0] last_q = '0;

    prog_flag_fifo #(.DEPTH(DEPTH)) u_dut (
        .wclk(wclk), .rclk(rclk), .rst(rst),
        .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld), .wr_data(wr_data),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .out_en_n(out_en_n),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .rd_q(rd_q), .full_n(full_n), .afull_n(afull_n),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    initial forever #(WCLK_PERIOD/2) wclk = ~wclk;
    initial begin
        #2;
        forever #(RCLK_PERIOD/2) rclk = ~rclk;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
    endtask

    task automatic do_reset(input logic cfg);
        @(negedge wclk);
        rst = 1'b1;
        wr_en2_ld = cfg;
        dual = cfg;
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        rst = 1'b0;
        wr_en2_ld = 1'b0;
        model.delete();
        last_q = '0;
        settle();
    endtask

    // Expected flags from the count, offsets n (empty) and m (full)
    task automatic check_flags(input string req, input int n, input int m);
        int c;
        c = model.size();
        check({req, " full_n"},   32'(full_n),   32'(c != DEPTH));
        check({req, " afull_n"},  32'(afull_n),  32'(c < DEPTH - m));
        check({req, " empty_n"},  32'(empty_n),  32'(c != 0));
        check({req, " aempty_n"}, 32'(aempty_n), 32'(c > n));
    endtask

    task automatic write_words(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge wclk);
            if (i > 0) check("R7 full_n after write edge", 32'(full_n), 32'(model.size() != DEPTH));
            wr_data   = 9'(seq * 37 + 5);
            wr_en1_n  = 1'b0;
            wr_en2_ld = dual;
            if (model.size() < DEPTH) model.push_back(wr_data);
            seq++;
        end
        @(negedge wclk);
        wr_en1_n  = 1'b1;
        wr_en2_ld = 1'b0;
        if (k > 0) check("R7 full_n after write edge", 32'(full_n), 32'(model.size() != DEPTH));
    endtask

    task automatic read_one(input string req);
        logic [8:0] exp;
        @(negedge rclk);
        rd_en1_n = 1'b0;
        rd_en2_n = 1'b0;
        @(negedge rclk);
        rd_en1_n = 1'b1;
        rd_en2_n = 1'b1;
        if (model.size() > 0) begin
            exp = model.pop_front();
            last_q = exp;
        end else begin
            exp = last_q;
        end
        check(req, 32'(rd_q), 32'(exp));
    endtask

    task automatic sweep(input int n, input int m);
        for (int k = 0; k <= DEPTH; k++) begin
            write_words(k);
            settle();
            check_flags(dual ? "R9 R11 sweep" : "R8 R9 sweep", n, m);
            for (int j = 0; j < k; j++) read_one("R6 data order");
            settle();
            check_flags("R9 drained", n, m);
        end
    endtask

    initial begin
        #(WATCHDOG);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(1'b0);
        check_flags("R1 reset", 0, 0);
        check("R1 output register", 32'(rd_q), 32'h0);

        // R10: tri-state
        @(negedge rclk);
        out_en_n = 1'b1;
        #1;
        check("R10 high-z", 32'(rd_q === 9'bz), 32'h1);
        out_en_n = 1'b0;
        #1;
        check("R10 driven", 32'(rd_q), 32'h0);

        // R2: programmable mode writes with wr_en2_ld low
        write_words(1);
        settle();
        check("R2 prog write accepted", 32'(empty_n), 32'h1);
        read_one("R2 data");

        // R4: one read enable alone does nothing
        write_words(2);
        settle();
        @(negedge rclk);
        rd_en1_n = 1'b0;
        @(negedge rclk);
        rd_en1_n = 1'b1;
        rd_en2_n = 1'b0;
        @(negedge rclk);
        rd_en2_n = 1'b1;
        check("R4 q holds", 32'(rd_q), 32'(last_q));
        settle();
        empty_ofs = 4'd1;
        #1;
        check("R4 count held", 32'(aempty_n), 32'h1);
        read_one("R4 first word after hold");
        read_one("R4 second word");
        settle();

        // R5: overflow and underflow ignored
        write_words(DEPTH + 3);
        settle();
        check("R5 full", 32'(full_n), 32'h0);
        for (int j = 0; j < DEPTH; j++) read_one("R5 R6 data after overflow");
        settle();
        check("R5 empty", 32'(empty_n), 32'h0);
        read_one("R5 underflow holds q");
        write_words(1);
        settle();
        read_one("R5 pointer intact");
        settle();

        // R8 R9 sweeps in programmable mode
        empty_ofs = 4'd3;  full_ofs = 4'd5;  sweep(3, 5);
        empty_ofs = 4'd0;  full_ofs = 4'd0;  sweep(0, 0);
        empty_ofs = 4'd15; full_ofs = 4'd15; sweep(15, 15);

        // R1: reset while holding data
        write_words(5);
        do_reset(1'b1);
        check_flags("R1 reset with data", 7, 7);
        check("R1 q cleared", 32'(rd_q), 32'h0);

        // R3: dual-enable mode gating
        @(negedge wclk);
        wr_data = 9'h1AA; wr_en1_n = 1'b0; wr_en2_ld = 1'b0;
        @(negedge wclk);
        wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
        @(negedge wclk);
        wr_en2_ld = 1'b0;
        settle();
        check("R3 no write with one enable", 32'(empty_n), 32'h0);

        // R11: offsets ignored in dual-enable mode
        empty_ofs = 4'd2; full_ofs = 4'd2;
        sweep(7, 7);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule